// File: doc/BRIEF.md
# Oversampling Serial Receiver with Sticky Error Flags

This block receives asynchronous serial characters. It runs on its own receive clock at sixteen times the bit rate. It brings the serial line into that clock domain through a short synchronizer and waits for a falling edge. Half a bit later it confirms the start bit, then samples every following bit at its centre. Each completed character is placed into a receive buffer, and a data-received flag is raised for the host.

The character format is set by three inputs: word length (5 to 8 bits), parity enable and parity sense. The receiver checks only the first stop bit, so the stop-bit count of the far end does not affect it. Parity, framing and overrun problems are reported on three flags. Once a flag is set, only the master reset clears it. The host acknowledges a character by pulsing an active-low acknowledge input, which drops data-received and leaves the error flags alone. The master reset clears data-received and the flags asynchronously, returns the receiver to idle and leaves the receive buffer as it was.

Top module: `serial_rx_sticky`

## Requirements
- R1: While `rst_n` is low, `rx_valid`, `err_parity`, `err_frame` and `err_overrun` are 0, and the line state machine is idle. The clear of these four outputs is asynchronous.
- R2: Asserting `rst_n` low does not change the value of `rx_data`.
- R3: A start bit is accepted only if the line is still low 8 receive-clock cycles after the falling edge is seen. A shorter low pulse produces no character.
- R4: Data bits arrive least significant bit first, and are sampled every 16 cycles after the start sample. `cfg_len` encodes the word length as 0=5, 1=6, 2=7 and 3=8 bits. `rx_data` bits above the word length read 0.
- R5: `rx_valid` rises after the first stop bit has been sampled, and not before that point in the frame.
- R6: When `cfg_par_en`=1, one parity bit follows the data. With `cfg_par_even`=1, the data bits and the parity bit must together hold an even number of ones; with `cfg_par_even`=0 they must hold an odd number. A mismatch sets `err_parity`, and the character is still delivered.
- R7: A low first stop bit sets `err_frame`.
- R8: A character that completes while `rx_valid` is 1 and `dr_clr_n` is 1 sets `err_overrun`, and the new character replaces the buffer contents.
- R9: Holding `dr_clr_n` low for one cycle clears `rx_valid`. It does not change `rx_data`.
- R10: `err_parity`, `err_frame` and `err_overrun` stay set through acknowledges and later error-free characters, until `rst_n` is asserted.
- R11: After `rst_n` is released, the receiver accepts a new character normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, 16 times the bit rate |
| rst_n | input | 1 | Master reset, active low |
| rx_in | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Word length code (0=5 ... 3=8 bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| dr_clr_n | input | 1 | Data-received acknowledge, active low |
| rx_data | output | 8 | Receive buffer, right-aligned |
| rx_valid | output | 1 | Data received |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
A wrong sampling counter or bit index corrupts the buffer, and the corruption is visible in `rx_data` as soon as that character completes, roughly ten cycles into its stop bit. A parity accumulator or state machine left in the wrong state shows up as a false or missing flag on that same character. Errors in the sticky logic can only be seen across characters, so the bench follows each error with acknowledges and clean characters. The bench also sweeps every word length with every parity setting and several bit patterns, so that each bit position and each parity outcome is reached.

// File: rtl/serial_rx_pkg.sv
// Shared types for the oversampling serial receiver.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package serial_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_phase_t;

endpackage

// File: rtl/serial_rx_sync.sv
// Line synchronizer: carries the asynchronous serial input into the
// receive clock domain through a chain of flops.
// Assumes STAGES >= 2; the chain resets to the idle (high) line level.
module serial_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    // Shift the raw line level through the chain, idle-high on reset.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/serial_rx_frame.sv
// Frame engine: detects the start edge, confirms it at mid-bit,
// samples data, optional parity and the first stop bit at bit centres,
// and emits a one-cycle done pulse with the character and its errors.
// Assumes the format inputs are stable while a character is in flight.
module serial_rx_frame
    import serial_rx_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_s,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);

    localparam int CNT_W   = $clog2(OVS);
    localparam int HALF    = OVS / 2;
    localparam int BIT_W   = $clog2(DATA_W + 1);
    localparam int MIN_LEN = DATA_W - (2 ** LEN_W) + 1;

    rx_phase_t         phase;
    logic [CNT_W-1:0]  tick;
    logic [BIT_W-1:0]  bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic [BIT_W-1:0]  last_idx;
    logic [BIT_W-1:0]  shift_amt;
    logic              at_centre;

    assign last_idx  = BIT_W'(MIN_LEN - 1) + BIT_W'(cfg_len);
    assign shift_amt = BIT_W'(DATA_W - 1) - last_idx;
    assign at_centre = (tick == CNT_W'(OVS - 1));

    // Right-align the received bits; vacated upper bits fill with zero.
    assign data = shreg >> shift_amt;

    // Frame sequencing, bit-centre sampling and error evaluation.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= RX_IDLE;
            tick    <= '0;
            bit_idx <= '0;
            shreg   <= '0;
            par_acc <= 1'b0;
            done    <= 1'b0;
            perr    <= 1'b0;
            ferr    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                RX_IDLE: begin
                    tick    <= '0;
                    bit_idx <= '0;
                    par_acc <= 1'b0;
                    if (!rx_s) phase <= RX_START;
                end
                RX_START: begin
                    if (tick == CNT_W'(HALF - 1)) begin
                        tick  <= '0;
                        phase <= rx_s ? RX_IDLE : RX_DATA;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (at_centre) begin
                        tick    <= '0;
                        shreg   <= {rx_s, shreg[DATA_W-1:1]};
                        par_acc <= par_acc ^ rx_s;
                        if (bit_idx == last_idx) begin
                            phase <= cfg_par_en ? RX_PARITY : RX_STOP;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                RX_PARITY: begin
                    if (at_centre) begin
                        tick    <= '0;
                        par_acc <= par_acc ^ rx_s;
                        phase   <= RX_STOP;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (at_centre) begin
                        tick  <= '0;
                        done  <= 1'b1;
                        ferr  <= ~rx_s;
                        perr  <= cfg_par_en & (par_acc == cfg_par_even);
                        phase <= RX_IDLE;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: phase <= RX_IDLE;
            endcase
        end
    end

    // R5: a character spans many cycles, so done is never two cycles long.
    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: a start sampled high returns the engine to idle, not to data.
    p_false_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == RX_START && tick == CNT_W'(HALF - 1) && rx_s) |=> phase == RX_IDLE);

endmodule

// File: rtl/serial_rx_status.sv
// Host-side status: holds the receive buffer, the data-received flag and
// the three sticky error flags. The buffer has no reset on purpose, so a
// master reset leaves it unchanged.
// Assumes done is a single-cycle pulse from the frame engine.
module serial_rx_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              perr,
    input  logic              ferr,
    input  logic              dr_clr_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun
);

    // Capture each finished character; untouched by master reset.
    always_ff @(posedge clk) begin
        if (done) rx_data <= data;
    end

    // Data-received handshake and sticky error accumulation.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_valid    <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (done) begin
                rx_valid    <= 1'b1;
                err_parity  <= err_parity | perr;
                err_frame   <= err_frame | ferr;
                err_overrun <= err_overrun | (rx_valid & dr_clr_n);
            end else if (!dr_clr_n) begin
                rx_valid <= 1'b0;
            end
        end
    end

    // R10: error flags fall only through master reset.
    p_sticky_par_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_parity |=> err_parity);
    p_sticky_frm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_frame |=> err_frame);
    p_sticky_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_overrun |=> err_overrun);

    // R8: an unacknowledged character overwritten by a new one flags overrun.
    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_valid && dr_clr_n) |=> err_overrun);

    // R9: an acknowledge with no new character drops data-received and keeps the buffer.
    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dr_clr_n && !done) |=> (!rx_valid && $stable(rx_data)));

    // R5: a finished character always raises data-received.
    p_valid_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_valid);

endmodule

// File: rtl/serial_rx_sticky.sv
// Top of the oversampling serial receiver: synchronizer, frame engine and
// status/buffer stage. Runs entirely on the 16x receive clock.
// Assumes the format inputs change only while no character is in flight.
module serial_rx_sticky #(
    parameter int OVS         = 16,
    parameter int DATA_W      = 8,
    parameter int LEN_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              dr_clr_n,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun
);

    localparam int BIT_W   = $clog2(DATA_W + 1);
    localparam int MIN_LEN = DATA_W - (2 ** LEN_W) + 1;

    logic              rx_s;
    logic              done;
    logic [DATA_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic [BIT_W-1:0]  word_bits;

    assign word_bits = BIT_W'(MIN_LEN) + BIT_W'(cfg_len);

    serial_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_in),
        .dout (rx_s)
    );

    serial_rx_frame #(.OVS(OVS), .DATA_W(DATA_W), .LEN_W(LEN_W)) frame_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_s        (rx_s),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_even(cfg_par_even),
        .done        (done),
        .data        (data),
        .perr        (perr),
        .ferr        (ferr)
    );

    serial_rx_status #(.DATA_W(DATA_W)) status_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .done       (done),
        .data       (data),
        .perr       (perr),
        .ferr       (ferr),
        .dr_clr_n   (dr_clr_n),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .err_parity (err_parity),
        .err_frame  (err_frame),
        .err_overrun(err_overrun)
    );

    // R4: a held character carries no bits above the configured word length.
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> ((rx_data >> word_bits) == '0));

endmodule

// File: tb/serial_rx_sticky_tb_top.sv
// Self-checking bench: sweeps word length, parity mode and bit patterns,
// then walks through false start, each error, stickiness and master reset.
module serial_rx_sticky_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  BIT_T      = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       dr_clr_n = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       err_parity;
    logic       err_frame;
    logic       err_overrun;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    serial_rx_sticky dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_in       (rx_in),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_even(cfg_par_even),
        .dr_clr_n    (dr_clr_n),
        .rx_data     (rx_data),
        .rx_valid    (rx_valid),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_overrun (err_overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    task automatic hold_bit(input logic v);
        rx_in = v;
        repeat (BIT_T) @(negedge clk);
    endtask

    // Send one frame with nb data bits; optional corrupted parity or stop bit.
    task automatic send_frame(input logic [7:0] d, input int nb, input bit pen,
                              input bit peven, input bit bad_par, input bit bad_stop);
        logic p;
        p = 1'b0;
        hold_bit(1'b0);
        for (int i = 0; i < nb; i++) begin
            hold_bit(d[i]);
            p = p ^ d[i];
        end
        if (pen) begin
            if (!peven) p = ~p;
            hold_bit(p ^ bad_par);
        end
        hold_bit(~bad_stop);
        rx_in = 1'b1;
        repeat (24) @(negedge clk);
    endtask

    task automatic ack();
        dr_clr_n = 1'b0;
        @(negedge clk);
        dr_clr_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] pats [8];
        logic [7:0] mask;
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h5A;
        pats[4] = 8'h01; pats[5] = 8'h80; pats[6] = 8'h3C; pats[7] = 8'hE7;

        repeat (4) @(negedge clk);
        // R1: outputs cleared during reset
        chk("R1 valid", rx_valid, 0);
        chk("R1 flags", {err_parity, err_frame, err_overrun}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4 R6 R5 R9: sweep length x parity mode x pattern
        for (int L = 0; L < 4; L++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int k = 0; k < 8; k++) begin
                    cfg_len      = 2'(L);
                    cfg_par_en   = (pm != 0);
                    cfg_par_even = (pm == 1);
                    mask = 8'((9'h1 << (L + 5)) - 1);
                    send_frame(pats[k], L + 5, pm != 0, pm == 1, 1'b0, 1'b0);
                    chk("R4 data", rx_data, pats[k] & mask);
                    chk("R5 valid", rx_valid, 1);
                    chk("R6 no parity err", err_parity, 0);
                    ack();
                    chk("R9 ack clears valid", rx_valid, 0);
                    chk("R9 ack keeps data", rx_data, pats[k] & mask);
                end
            end
        end

        // R5: valid not raised before the stop bit
        cfg_len = 2'd3; cfg_par_en = 1'b0;
        hold_bit(1'b0);
        for (int i = 0; i < 8; i++) hold_bit(1'b1);
        chk("R5 not early", rx_valid, 0);
        hold_bit(1'b1);
        repeat (24) @(negedge clk);
        chk("R5 after stop", rx_valid, 1);
        chk("R5 data", rx_data, 8'hFF);
        ack();

        // R3: short low pulse is rejected
        rx_in = 1'b0;
        repeat (4) @(negedge clk);
        rx_in = 1'b1;
        repeat (60) @(negedge clk);
        chk("R3 glitch valid", rx_valid, 0);
        chk("R3 glitch flags", {err_parity, err_frame, err_overrun}, 0);

        // R6: wrong parity, character still delivered
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_even = 1'b1;
        send_frame(8'h96, 8, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R6 parity err", err_parity, 1);
        chk("R6 data kept", rx_data, 8'h96);
        chk("R6 valid", rx_valid, 1);
        ack();
        // R10: sticky through ack and a clean character
        send_frame(8'h11, 8, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R10 parity sticky", err_parity, 1);
        chk("R10 frame clear", err_frame, 0);
        ack();

        // R7: low stop bit
        cfg_par_en = 1'b0;
        send_frame(8'h42, 8, 1'b0, 1'b0, 1'b0, 1'b1);
        chk("R7 frame err", err_frame, 1);
        chk("R7 data", rx_data, 8'h42);
        ack();
        repeat (40) @(negedge clk);
        chk("R7 no spurious char", rx_valid, 0);

        // R8: two characters without acknowledge
        chk("R8 overrun clear before", err_overrun, 0);
        send_frame(8'h33, 8, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 first no overrun", err_overrun, 0);
        send_frame(8'hC4, 8, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R8 overrun", err_overrun, 1);
        chk("R8 buffer replaced", rx_data, 8'hC4);
        ack();
        send_frame(8'h21, 8, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10 all sticky", {err_parity, err_frame, err_overrun}, 3'b111);

        // R1 R2: master reset clears flags, keeps buffer
        rst_n = 1'b0;
        #1;
        chk("R1 async valid", rx_valid, 0);
        chk("R1 async flags", {err_parity, err_frame, err_overrun}, 0);
        repeat (3) @(negedge clk);
        chk("R2 buffer kept", rx_data, 8'h21);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: normal reception after reset
        cfg_len = 2'd1; cfg_par_en = 1'b1; cfg_par_even = 1'b0;
        send_frame(8'h2D, 6, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R11 data", rx_data, 8'h2D);
        chk("R11 valid", rx_valid, 1);
        chk("R11 flags", {err_parity, err_frame, err_overrun}, 0);

        finish_run();
    end

endmodule